// File: doc/BRIEF.md
# Arbitrated Serial EEPROM Bit-Bang Port

This block lets software drive a one-bit serial EEPROM by hand through a single eight-bit control register, while the EEPROM shares its pins with a memory port that other requesters also use. Software sets a request bit. The block waits until the memory port has no other requester holding it, then grants the EEPROM and raises a ready flag. From then on, the chip-select, clock and data-out bits of the register drive the EEPROM pins directly, and the EEPROM's data-out line is sampled into bit 0 of the register.

On the first grant, the ready flag only means that access was given and carries no timing. On every later register write while access is held, the flag drops and rises again after a fixed settle time of 800 ns. That time is a cycle count derived from the clock frequency, so software can pace each bit-bang step by polling the flag. Clearing the request bit releases the port at once. The command protocol of the EEPROM itself is left to software.

Top module: `nvm_serial_port`

## Requirements
- R1: After reset, the register reads 0x00, all three EEPROM pins are low and the memory-port grant is low.
- R2: When no requester holds the port and the memory requester is asserted, the memory grant rises at the next clock edge. If the EEPROM request and the memory requester arrive at the same edge, the memory requester wins. An EEPROM request that is pending while the memory grant is held stays ungranted (ready bit 4 reads 0) until the memory requester drops.
- R3: With the request bit (bit 5) set, the EEPROM is granted at the first edge at which the port is free. At that same edge the ready bit (bit 4) reads 1, with no delay.
- R4: While granted, a register write that keeps bit 5 at 1 clears the ready bit at the write edge. The ready bit returns to 1 exactly SETTLE_CYC edges later, where SETTLE_CYC = ceil(SETTLE_NS x CLK_MHZ / 1000), which is 160 by default. A write during the countdown restarts it.
- R5: While granted, the pins nvmCs, nvmClk and nvmDout follow register bits 3, 2 and 1. While not granted, all three pins are 0, whatever the bits hold.
- R6: While granted, bit 0 reads the value of nvmDin sampled at the previous clock edge. While not granted, bit 0 reads 0 from the edge after the grant ends.
- R7: A write with bit 5 at 0 releases the grant at the write edge. Ready and all pins go low at that edge. A waiting memory requester is granted at the following edge.
- R8: While the EEPROM holds the grant, the memory requester is ignored and memGnt stays 0.
- R9: Bits 7, 6, 4 and 0 cannot be written. Bits 7 and 6 always read 0, and bits 4 and 0 keep their own meaning whatever data is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the control register |
| regWrData | input | 8 | Write data for the control register |
| regRdData | output | 8 | Current contents of the control register |
| memReq | input | 1 | Request from the other memory-port user |
| memGnt | output | 1 | Grant to the other memory-port user |
| nvmCs | output | 1 | EEPROM chip select |
| nvmClk | output | 1 | EEPROM serial clock |
| nvmDout | output | 1 | Data to the EEPROM |
| nvmDin | input | 1 | Data from the EEPROM |

## Verification
Every register write, grant change and release shows in regRdData and on the pins at the clock edge that samples the stimulus, so it is due one edge later. The ready bit comes back exactly SETTLE_CYC edges after a write, and the sampled data-in bit trails nvmDin by one edge. The bench drives inputs just after a rising edge and compares every output against a behavioural model on every falling edge. Directed checks for each requirement sample after a counted number of edges, including one edge before and at the ready deadline.

// File: rtl/nvm_serial_pkg.sv
`timescale 1ns/1ps
package nvm_serial_pkg;

  // Control register bit positions (software-visible layout)
  localparam int BIT_DIN   = 0;
  localparam int BIT_DOUT  = 1;
  localparam int BIT_CLK   = 2;
  localparam int BIT_CS    = 3;
  localparam int BIT_READY = 4;
  localparam int BIT_REQ   = 5;
  localparam int REG_W     = 8;
  localparam int PIN_N     = 3;  // cs, clk, dout

  typedef enum logic [1:0] {
    ARB_FREE = 2'd0,
    ARB_MEM  = 2'd1,
    ARB_NVM  = 2'd2
  } arbState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic granted;
    logic ready;
  } ctrlStrb_t;

endpackage

// File: rtl/nvm_serial_ctrl.sv
`timescale 1ns/1ps
module nvm_serial_ctrl
  import nvm_serial_pkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int SETTLE_NS = 800
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      reqNext,
  input  logic      memReq,
  output logic      memGnt,
  output ctrlStrb_t strb
);

  localparam int SETTLE_RAW = (SETTLE_NS * CLK_MHZ + 999) / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int CNT_W      = $clog2(SETTLE_CYC + 1);

  arbState_t            arbState, arbNext;
  logic [CNT_W-1:0]     settleCnt;
  logic                 readyQ;

  // Arbitration: memory requester wins a tie from the free state
  always_comb begin
    arbNext = arbState;
    unique case (arbState)
      ARB_FREE: begin
        if (memReq)       arbNext = ARB_MEM;
        else if (reqNext) arbNext = ARB_NVM;
      end
      ARB_MEM: begin
        if (!memReq) arbNext = reqNext ? ARB_NVM : ARB_FREE;
      end
      ARB_NVM: begin
        if (!reqNext) arbNext = ARB_FREE;
      end
      default: arbNext = ARB_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arbState <= ARB_FREE;
    end else begin
      arbState <= arbNext;
    end
  end

  // Ready flag: immediate on first grant, settle timer after later writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      settleCnt <= '0;
    end else if (arbNext == ARB_NVM) begin
      if (arbState != ARB_NVM) begin
        readyQ    <= 1'b1;
        settleCnt <= '0;
      end else if (regWrEn) begin
        readyQ    <= 1'b0;
        settleCnt <= CNT_W'(SETTLE_CYC);
      end else if (settleCnt == CNT_W'(1)) begin
        readyQ    <= 1'b1;
        settleCnt <= '0;
      end else if (settleCnt != '0) begin
        settleCnt <= settleCnt - CNT_W'(1);
      end
    end else begin
      readyQ    <= 1'b0;
      settleCnt <= '0;
    end
  end

  assign memGnt       = (arbState == ARB_MEM);
  assign strb.granted = (arbState == ARB_NVM);
  assign strb.ready   = readyQ;

endmodule

// File: rtl/nvm_serial_dp.sv
`timescale 1ns/1ps
module nvm_serial_dp
  import nvm_serial_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  ctrlStrb_t        strb,
  input  logic             nvmDin,
  output logic             reqNext,
  output logic [REG_W-1:0] regRdData,
  output logic [PIN_N-1:0] pinOut
);

  // pin index 0 = dout, 1 = clk, 2 = cs (matches register bits 1..3)
  logic [PIN_N-1:0] drvBits;
  logic             reqBit;
  logic             dinBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqBit <= 1'b0;
    end else if (regWrEn) begin
      reqBit <= regWrData[BIT_REQ];
    end
  end

  generate
    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          drvBits[i] <= 1'b0;
        end else if (regWrEn) begin
          drvBits[i] <= regWrData[BIT_DOUT + i];
        end
      end
      assign pinOut[i] = strb.granted & drvBits[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dinBit <= 1'b0;
    end else begin
      dinBit <= strb.granted & nvmDin;
    end
  end

  assign reqNext = regWrEn ? regWrData[BIT_REQ] : reqBit;

  always_comb begin
    regRdData            = '0;
    regRdData[BIT_REQ]   = reqBit;
    regRdData[BIT_READY] = strb.ready;
    regRdData[BIT_CS]    = drvBits[2];
    regRdData[BIT_CLK]   = drvBits[1];
    regRdData[BIT_DOUT]  = drvBits[0];
    regRdData[BIT_DIN]   = dinBit;
  end

endmodule

// File: rtl/nvm_serial_port.sv
`timescale 1ns/1ps
module nvm_serial_port
  import nvm_serial_pkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int SETTLE_NS = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       memReq,
  output logic       memGnt,
  output logic       nvmCs,
  output logic       nvmClk,
  output logic       nvmDout,
  input  logic       nvmDin
);

  ctrlStrb_t        strb;
  logic             reqNext;
  logic [PIN_N-1:0] pinOut;

  nvm_serial_ctrl #(
    .CLK_MHZ  (CLK_MHZ),
    .SETTLE_NS(SETTLE_NS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regWrEn(regWrEn),
    .reqNext(reqNext),
    .memReq (memReq),
    .memGnt (memGnt),
    .strb   (strb)
  );

  nvm_serial_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strb     (strb),
    .nvmDin   (nvmDin),
    .reqNext  (reqNext),
    .regRdData(regRdData),
    .pinOut   (pinOut)
  );

  assign nvmDout = pinOut[0];
  assign nvmClk  = pinOut[1];
  assign nvmCs   = pinOut[2];

endmodule

// File: rtl/nvm_serial_port_chk.sv
`timescale 1ns/1ps
module nvm_serial_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       memGnt,
  input logic       nvmCs,
  input logic       nvmClk,
  input logic       nvmDout,
  input logic       granted
);

  // R8
  excl_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    granted |-> !memGnt);

  // R3
  grant_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(granted) |-> regRdData[4]);

  // R4
  wr_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (granted && regWrEn && regWrData[5]) |=> !regRdData[4]);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[5]) |=> (!granted && !regRdData[4] && !nvmCs && !nvmClk && !nvmDout));

  // R5
  pins_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !granted |-> !(nvmCs || nvmClk || nvmDout));

  // R9
  hi_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7:6] == 2'b00);

  // R6
  din_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!granted && !$past(granted)) |-> !regRdData[0]);

endmodule

bind nvm_serial_port nvm_serial_port_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .memGnt   (memGnt),
  .nvmCs    (nvmCs),
  .nvmClk   (nvmClk),
  .nvmDout  (nvmDout),
  .granted  (strb.granted)
);

// File: tb/nvm_serial_port_tb.sv
`timescale 1ns/1ps
module nvm_serial_port_tb;

  localparam int CLK_MHZ   = 200;
  localparam int SETTLE_NS = 800;
  localparam int SETTLE    = (SETTLE_NS * CLK_MHZ + 999) / 1000;  // 160

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       memReq = 1'b0;
  logic       memGnt;
  logic       nvmCs, nvmClk, nvmDout;
  logic       nvmDin = 1'b0;

  int testsRun = 0;
  int testsFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvm_serial_port #(.CLK_MHZ(CLK_MHZ), .SETTLE_NS(SETTLE_NS)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .memReq(memReq), .memGnt(memGnt),
    .nvmCs(nvmCs), .nvmClk(nvmClk), .nvmDout(nvmDout), .nvmDin(nvmDin)
  );

  // Behavioural reference: owner 0 free, 1 memory, 2 eeprom
  int mOwner = 0;
  bit mReq = 0, mCs = 0, mSk = 0, mDo = 0, mDi = 0, mReady = 0;
  int mCnt = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mOwner = 0; mReq = 0; mCs = 0; mSk = 0; mDo = 0; mDi = 0; mReady = 0; mCnt = 0;
    end else begin
      bit reqN;
      int nxt;
      reqN = regWrEn ? regWrData[5] : mReq;
      nxt = mOwner;
      if (mOwner == 0) nxt = memReq ? 1 : (reqN ? 2 : 0);
      else if (mOwner == 1) nxt = memReq ? 1 : (reqN ? 2 : 0);
      else nxt = reqN ? 2 : 0;
      mDi = (mOwner == 2) && nvmDin;
      if (nxt == 2) begin
        if (mOwner != 2) begin mReady = 1; mCnt = 0; end
        else if (regWrEn) begin mReady = 0; mCnt = SETTLE; end
        else if (mCnt > 0) begin
          mCnt--;
          if (mCnt == 0) mReady = 1;
        end
      end else begin
        mReady = 0; mCnt = 0;
      end
      if (regWrEn) begin
        mReq = regWrData[5]; mCs = regWrData[3]; mSk = regWrData[2]; mDo = regWrData[1];
      end
      mOwner = nxt;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison on every falling edge after reset
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit g;
      g = (mOwner == 2);
      chk("R9 regRdData vs model", regRdData, {2'b00, mReq, mReady, mCs, mSk, mDo, mDi});
      chk("R5 pins vs model", {5'd0, nvmCs, nvmClk, nvmDout}, {5'd0, g & mCs, g & mSk, g & mDo});
      chk("R2 memGnt vs model", {7'd0, memGnt}, {7'd0, mOwner == 1});
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrReg(input logic [7:0] d);
    regWrEn = 1'b1;
    regWrData = d;
    step(1);
    regWrEn = 1'b0;
    regWrData = 8'h00;
  endtask

  initial begin
    #(200000 * 5);
    testsFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1 reset regRdData", regRdData, 8'h00);
    chk("R1 reset pins", {5'd0, nvmCs, nvmClk, nvmDout}, 8'h00);
    chk("R1 reset memGnt", {7'd0, memGnt}, 8'h00);
    rstN = 1'b1;
    step(2);

    // R2 memory requester served, eeprom request waits
    memReq = 1'b1;
    step(1);
    chk("R2 memGnt rises", {7'd0, memGnt}, 8'h01);
    wrReg(8'h20);
    step(3);
    chk("R2 eeprom waits ready", {7'd0, regRdData[4]}, 8'h00);
    memReq = 1'b0;
    step(1);
    // R3 immediate ready on grant
    chk("R3 ready on grant", {7'd0, regRdData[4]}, 8'h01);

    // R8 memory requester ignored while granted
    memReq = 1'b1;
    step(5);
    chk("R8 memGnt held low", {7'd0, memGnt}, 8'h00);
    memReq = 1'b0;

    // R4 settle timing and R5 pins
    wrReg(8'h2E);
    chk("R4 ready low after write", {7'd0, regRdData[4]}, 8'h00);
    chk("R5 pins follow bits", {5'd0, nvmCs, nvmClk, nvmDout}, 8'h07);
    step(SETTLE - 1);
    chk("R4 ready still low one edge early", {7'd0, regRdData[4]}, 8'h00);
    step(1);
    chk("R4 ready high at deadline", {7'd0, regRdData[4]}, 8'h01);
    wrReg(8'h28);
    chk("R5 only cs driven", {5'd0, nvmCs, nvmClk, nvmDout}, 8'h04);
    step(50);
    wrReg(8'h2A);
    step(SETTLE - 1);
    chk("R4 restart early", {7'd0, regRdData[4]}, 8'h00);
    step(1);
    chk("R4 restart deadline", {7'd0, regRdData[4]}, 8'h01);

    // R6 data-in sampling
    nvmDin = 1'b1;
    step(1);
    chk("R6 din high", {7'd0, regRdData[0]}, 8'h01);
    nvmDin = 1'b0;
    step(1);
    chk("R6 din low", {7'd0, regRdData[0]}, 8'h00);

    // R9 read-only bits
    wrReg(8'hFF);
    chk("R9 read-only bits", regRdData, 8'h2E);
    step(SETTLE + 2);

    // R7 release with waiting memory requester
    memReq = 1'b1;
    nvmDin = 1'b1;
    wrReg(8'h0E);
    chk("R7 ready low on release", {7'd0, regRdData[4]}, 8'h00);
    chk("R7 pins low on release", {5'd0, nvmCs, nvmClk, nvmDout}, 8'h00);
    step(1);
    chk("R7 memory granted next", {7'd0, memGnt}, 8'h01);
    chk("R6 din zero ungranted", {7'd0, regRdData[0]}, 8'h00);
    nvmDin = 1'b0;

    // R2 tie from the free state goes to memory
    memReq = 1'b0;
    step(2);
    memReq = 1'b1;
    wrReg(8'h20);
    chk("R2 tie to memory", {7'd0, memGnt}, 8'h01);
    chk("R2 tie ready low", {7'd0, regRdData[4]}, 8'h00);
    memReq = 1'b0;
    step(1);
    chk("R3 grant after memory drop", {7'd0, regRdData[4]}, 8'h01);
    wrReg(8'h00);
    step(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule